// File: doc/BRIEF.md
# Pin Controller with Sticky Edge Interrupts

This block manages 28 general-purpose pins on behalf of a processor that reaches it over a plain 32-bit register bus. Software chooses, per pin, whether the pin drives out or listens. Driven values live in an output latch that is never written directly. One register raises chosen latch bits and a second register lowers chosen latch bits, so one pin can be changed without a read-modify-write of the others. The present pin values, after synchronisation, can be read back at any time.

Every pin input passes through a two-stage synchroniser. Two enable masks, one for rising transitions and one for falling transitions, decide which changes are latched into a sticky status register. Software clears that register by writing ones to it. Status bits 0 to 10 each drive a dedicated interrupt line. Status bits 11 to 27 are ORed onto a single shared line. To silence a pin, both of its enable bits are cleared. A further register holds an alternate-function selection, which is storage only.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset the direction, output latch, rising-enable, falling-enable, edge-status and alternate-function registers are all zero, so pad_out_o, pad_oe_o, irq_pin_o and irq_shared_o are low.
- R2: Writing offset 0x08 sets every latch bit whose write-data bit is 1 and leaves the others unchanged. pad_out_o shows the result after that clock edge. Reads of 0x08 return 0.
- R3: Writing offset 0x0C clears every latch bit whose write-data bit is 1 and leaves the others unchanged. Reads of 0x0C return 0.
- R4: Offset 0x04 holds the direction mask (1 = output), read back in bits 27:0, and pad_oe_o follows it after the write edge.
- R5: Reading offset 0x00 returns pad_in_i delayed by two clock edges in bits 27:0. Writes to 0x00 have no effect.
- R6: With bit n of the rising-enable register (0x10) set, a 0-to-1 change of synchronised pin n sets status bit n, visible on the third clock edge after the pin changes.
- R7: With bit n of the falling-enable register (0x14) set, a 1-to-0 change of synchronised pin n sets status bit n. With both enables set, either change is recorded.
- R8: Status bits (0x18) stay set until software writes 1 to them. Written zeros leave bits unchanged, and an all-ones write clears every bit.
- R9: When a new edge and a clearing write for the same status bit land on the same clock edge, the bit ends up set.
- R10: irq_pin_o[n] equals status bit n for n = 0 to 10, and irq_shared_o is the OR of status bits 11 to 27.
- R11: A pin with both enable bits clear never gets a new status bit, and a bit already set on it is kept.
- R12: Offset 0x1C stores bits 27:0 of the written word and reads them back, with bits 31:28 reading 0. The same upper-bit rule holds for all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset; bits 4:2 pick the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not selected |
| pad_in_i | input | 28 | Asynchronous pin inputs |
| pad_out_o | output | 28 | Output latch |
| pad_oe_o | output | 28 | Output enable per pin (direction mask) |
| irq_pin_o | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared_o | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
The properties assume one bus transfer per cycle, with the strobe and the write flag stable across the clock edge, and pin inputs that settle outside the sampling edge. The bench meets this by driving every input on the falling clock edge. It issues single-cycle writes only. In the random part it changes at most one pin at a time and waits until the synchronisers and the edge detector have settled, so its model can predict the status register exactly. The same-edge collision between a new edge and a clearing write is built on purpose in one directed case.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6,
    REG_ALT   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= din;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int NPIN = 28
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_idx_e        wr_idx,
  input  logic [NPIN-1:0] wd,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] latch_q,
  output logic [NPIN-1:0] rise_q,
  output logic [NPIN-1:0] fall_q,
  output logic [NPIN-1:0] alt_q
);
  logic [NPIN-1:0] dir_d, latch_d, rise_d, fall_d, alt_d;

  always_comb begin
    dir_d   = dir_q;
    latch_d = latch_q;
    rise_d  = rise_q;
    fall_d  = fall_q;
    alt_d   = alt_q;
    if (wr_en) begin
      unique case (wr_idx)
        REG_DIR:  dir_d   = wd;
        REG_SET:  latch_d = latch_q | wd;
        REG_CLR:  latch_d = latch_q & ~wd;
        REG_RISE: rise_d  = wd;
        REG_FALL: fall_d  = wd;
        REG_ALT:  alt_d   = wd;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      alt_q   <= '0;
    end else if (wr_en) begin
      dir_q   <= dir_d;
      latch_q <= latch_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      alt_q   <= alt_d;
    end
  end
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int NPIN = 28
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic [NPIN-1:0] level,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] stat_q
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] stat_d;

  always_comb begin
    hit    = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);
    stat_d = (stat_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= level;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
  parameter int NPIN = 28,
  parameter int NDED = 11
) (
  input  logic [NPIN-1:0] stat,
  output logic [NDED-1:0] irq_pin,
  output logic            irq_shared
);
  localparam int NSHR = NPIN - NDED;

  for (genvar g = 0; g < NDED; g++) begin : g_ded
    assign irq_pin[g] = stat[g];
  end

  if (NSHR > 0) begin : g_shr
    assign irq_shared = |stat[NPIN-1:NDED];
  end else begin : g_noshr
    assign irq_shared = 1'b0;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPIN   = 28,
  parameter int NDED   = 11,
  parameter int DW     = 32,
  parameter int AW     = 5,
  parameter int SYNC_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [NPIN-1:0] pad_in_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o,
  output logic [NDED-1:0] irq_pin_o,
  output logic            irq_shared_o
);
  localparam int PAD_W = DW - NPIN;

  logic [1:0]      rst_q;
  logic            rst_n_int;
  reg_idx_e        idx;
  logic            wr_en;
  logic [NPIN-1:0] wd;
  logic [NPIN-1:0] level, dir_q, latch_q, rise_en, fall_en, alt_q;
  logic [NPIN-1:0] edge_stat, clr_mask;
  logic [NPIN-1:0] rd_val;
  logic            unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  assign idx      = reg_idx_e'(bus_addr_i[4:2]);
  assign wr_en    = bus_sel_i & bus_wr_i;
  assign wd       = bus_wdata_i[NPIN-1:0];
  assign clr_mask = (wr_en && idx == REG_STAT) ? wd : '0;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[DW-1:NPIN]};

  gpio_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n_int),
    .din   (pad_in_i),
    .dout  (level)
  );

  gpio_regfile #(.NPIN(NPIN)) u_regs (
    .clk_i   (clk_i),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wd      (wd),
    .dir_q   (dir_q),
    .latch_q (latch_q),
    .rise_q  (rise_en),
    .fall_q  (fall_en),
    .alt_q   (alt_q)
  );

  gpio_edge_unit #(.NPIN(NPIN)) u_edge (
    .clk_i    (clk_i),
    .rst_n    (rst_n_int),
    .level    (level),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .clr_mask (clr_mask),
    .stat_q   (edge_stat)
  );

  gpio_irq_map #(.NPIN(NPIN), .NDED(NDED)) u_irq (
    .stat       (edge_stat),
    .irq_pin    (irq_pin_o),
    .irq_shared (irq_shared_o)
  );

  always_comb begin
    unique case (idx)
      REG_LEVEL: rd_val = level;
      REG_DIR:   rd_val = dir_q;
      REG_RISE:  rd_val = rise_en;
      REG_FALL:  rd_val = fall_en;
      REG_STAT:  rd_val = edge_stat;
      REG_ALT:   rd_val = alt_q;
      default:   rd_val = '0;
    endcase
  end

  assign bus_rdata_o = bus_sel_i ? {{PAD_W{1'b0}}, rd_val} : '0;
  assign pad_out_o   = latch_q;
  assign pad_oe_o    = dir_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NPIN = 28,
  parameter int NDED = 11,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            bus_sel_i,
  input logic            bus_wr_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [NPIN-1:0] pad_out_o,
  input logic [NPIN-1:0] pad_oe_o,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] ren,
  input logic [NPIN-1:0] fen,
  input logic [NDED-1:0] irq_pin_o,
  input logic            irq_shared_o
);
  logic            w_set, w_clr, w_dir, w_stat;
  logic [NPIN-1:0] wv;

  assign wv     = bus_wdata_i[NPIN-1:0];
  assign w_dir  = bus_sel_i && bus_wr_i && bus_addr_i[4:2] == 3'd1;
  assign w_set  = bus_sel_i && bus_wr_i && bus_addr_i[4:2] == 3'd2;
  assign w_clr  = bus_sel_i && bus_wr_i && bus_addr_i[4:2] == 3'd3;
  assign w_stat = bus_sel_i && bus_wr_i && bus_addr_i[4:2] == 3'd6;

  AST_LATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_set |=> ((pad_out_o & $past(wv)) == $past(wv))); // R2
  AST_LATCH_CLR: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_clr |=> ((pad_out_o & $past(wv)) == '0)); // R3
  AST_OE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n)
    w_dir |=> (pad_oe_o == $past(wv))); // R4
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !w_stat |=> (($past(stat) & ~stat) == '0)); // R8
  AST_MASKED_PIN: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(ren | fen)) == '0)); // R11
  AST_IRQ_DED: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_pin_o == stat[NDED-1:0]); // R10
  AST_IRQ_SHR: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_shared_o == (|stat[NPIN-1:NDED])); // R10
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPIN(NPIN), .NDED(NDED), .DW(DW), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_int),
  .bus_sel_i    (bus_sel_i),
  .bus_wr_i     (bus_wr_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .pad_out_o    (pad_out_o),
  .pad_oe_o     (pad_oe_o),
  .stat         (edge_stat),
  .ren          (rise_en),
  .fen          (fall_en),
  .irq_pin_o    (irq_pin_o),
  .irq_shared_o (irq_shared_o)
);

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [27:0] pad_in = '0;
  logic [27:0] pad_out, pad_oe;
  logic [10:0] irq_pin;
  logic        irq_shr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [27:0] m_latch = '0, m_dir = '0, m_ren = '0, m_fen = '0, m_stat = '0, m_alt = '0, m_pad = '0;

  always #4 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .irq_pin_o(irq_pin), .irq_shared_o(irq_shr)
  );

  function automatic logic [27:0] edges(logic [27:0] o, logic [27:0] n, logic [27:0] r, logic [27:0] f);
    return (n & ~o & r) | (~n & o & f);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic move_pads(logic [27:0] v);
    @(negedge clk);
    m_stat = m_stat | edges(m_pad, v, m_ren, m_fen);
    m_pad  = v;
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stat(string req);
    logic [31:0] d;
    rd_reg(5'h18, d);
    check(req, d, {4'h0, m_stat});
    check({req, "_irq"}, {20'h0, irq_pin, irq_shr}, {20'h0, m_stat[10:0], |m_stat[27:11]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1_outs", {4'h0, pad_out}, 32'h0);
    check("R1_oe", {4'h0, pad_oe}, 32'h0);
    foreach (d[i]) ;
    for (int a = 1; a < 8; a++) begin
      rd_reg(5'(a * 4), d);
      check("R1_reg", d, 32'h0);
    end
    check("R1_irq", {20'h0, irq_pin, irq_shr}, 32'h0);

    // R5 level readback, write ignored
    move_pads(28'hA5A5A5A);
    rd_reg(5'h00, d); check("R5_level", d, 32'h0A5A5A5A);
    wr_reg(5'h00, 32'hFFFFFFFF);
    rd_reg(5'h00, d); check("R5_wr_ignored", d, 32'h0A5A5A5A);

    // R4 direction
    wr_reg(5'h04, 32'h00F0F0F0); m_dir = 28'h0F0F0F0;
    check("R4_oe", {4'h0, pad_oe}, 32'h00F0F0F0);
    rd_reg(5'h04, d); check("R4_rd", d, 32'h00F0F0F0);

    // R2 / R3 latch
    wr_reg(5'h08, 32'h000000F5); m_latch = 28'hF5;
    check("R2_set", {4'h0, pad_out}, 32'hF5);
    rd_reg(5'h08, d); check("R2_rd0", d, 32'h0);
    wr_reg(5'h0C, 32'h00000005); m_latch = 28'hF0;
    check("R3_clr", {4'h0, pad_out}, 32'hF0);
    rd_reg(5'h0C, d); check("R3_rd0", d, 32'h0);

    // R12 alternate-function storage
    wr_reg(5'h1C, 32'hFFFFFFFF); m_alt = 28'hFFFFFFF;
    rd_reg(5'h1C, d); check("R12_alt", d, 32'h0FFFFFFF);

    // R6 rising, R11 unenabled pin ignored
    move_pads(28'h0);
    wr_reg(5'h18, 32'hFFFFFFFF); m_stat = '0;
    wr_reg(5'h10, 32'h8); m_ren = 28'h8;
    move_pads(28'h18);
    check_stat("R6_rise");
    check("R11_unenabled", {31'h0, irq_pin[4]}, 32'h0);

    // R7 falling on shared group
    wr_reg(5'h14, 32'h00100000); m_fen = 28'h0100000;
    move_pads(28'h0100018);
    move_pads(28'h0000018);
    check_stat("R7_fall");
    check("R10_shared", {31'h0, irq_shr}, 32'h1);

    // R8 partial clear
    wr_reg(5'h18, 32'h8); m_stat[3] = 1'b0;
    check_stat("R8_partial");
    wr_reg(5'h18, 32'hFFFFFFFF); m_stat = '0;
    check_stat("R8_all");

    // R9 edge and clear on the same edge
    wr_reg(5'h10, 32'h28); m_ren = 28'h28;
    move_pads(28'h38);
    move_pads(28'h18);
    @(negedge clk); pad_in = 28'h38; m_pad = 28'h38;
    @(negedge clk);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = 5'h18; wdata = 32'h20;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
    repeat (2) @(negedge clk);
    check_stat("R9_set_wins");
    wr_reg(5'h18, 32'h20); m_stat[5] = 1'b0;
    check_stat("R9_then_clear");

    // R11 masked pin keeps old status
    move_pads(28'h18);
    move_pads(28'h38);
    wr_reg(5'h10, 32'h0); m_ren = '0;
    wr_reg(5'h14, 32'h0); m_fen = '0;
    move_pads(28'h0);
    move_pads(28'hFFFFFFF);
    check_stat("R11_masked");

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [27:0] v;
      int op;
      v  = 28'($urandom());
      op = $urandom_range(0, 7);
      case (op)
        0: begin wr_reg(5'h08, {4'hF, v}); m_latch |= v; check("R2_rand", {4'h0, pad_out}, {4'h0, m_latch}); end
        1: begin wr_reg(5'h0C, {4'hF, v}); m_latch &= ~v; check("R3_rand", {4'h0, pad_out}, {4'h0, m_latch}); end
        2: begin wr_reg(5'h04, {4'hF, v}); m_dir = v; check("R4_rand", {4'h0, pad_oe}, {4'h0, m_dir}); end
        3: begin wr_reg(5'h10, {4'hF, v}); m_ren = v; rd_reg(5'h10, d); check("R6_rand_en", d, {4'h0, m_ren}); end
        4: begin wr_reg(5'h14, {4'hF, v}); m_fen = v; rd_reg(5'h14, d); check("R7_rand_en", d, {4'h0, m_fen}); end
        5: begin wr_reg(5'h18, {4'h0, v}); m_stat &= ~v; check_stat("R8_rand"); end
        6: begin
             move_pads(m_pad ^ (28'h1 << $urandom_range(0, 27)));
             rd_reg(5'h00, d); check("R5_rand", d, {4'h0, m_pad});
             check_stat("R6_R7_rand");
           end
        default: begin wr_reg(5'h1C, {4'hF, v}); m_alt = v; rd_reg(5'h1C, d); check("R12_rand", d, {4'h0, m_alt}); end
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule